// File: doc/BRIEF.md
# Serial Auto-Baud Boot Handshake

This block lets a boot loader find the bit rate of a host on an asynchronous serial line without a preset divisor. After reset it waits for the receive line to sit high, then counts the clock cycles of the next low pulse. The host sends the byte 0x00 framed as 8 data bits, one stop bit and no parity. In that frame the start bit and the eight zero data bits form one unbroken low stretch of nine bit times. The block divides the count by nine and rounds it to get a bit-period divisor in clock cycles.

Next the line must stay high for at least one bit period. The block then answers with one 0x00 byte at the derived rate and listens for a single 0x55 byte from the host. It samples that byte at mid-bit with the same divisor. A correct byte raises the locked flag, and from then on the divisor is frozen and the serial line is ignored. The wrong byte, or a stop bit read as low, raises the error flag and sends the block back to measuring. A low pulse whose length lies outside the window for host rates of 9600 to 19200 bit/s at the configured clock is discarded without any reply.

Top module: `autobaud_boot`

## Requirements
- R1: While reset is held and right after its release, txdOut is 1, baudLocked is 0, syncError is 0 and bitDivisor is 0.
- R2: An accepted low pulse of L clock cycles sets bitDivisor to floor((L+4)/9), which is L/9 rounded to the nearest integer (724 gives 80, 725 gives 81). The value appears before the acknowledge frame begins.
- R3: The line must then stay high for one bit period. After that, txdOut sends 0x00 as a start bit (0), eight data bits sent LSB first and a stop bit (1), each lasting bitDivisor cycles. txdOut is therefore low for exactly 9*bitDivisor cycles and then returns high.
- R4: A low pulse is accepted only if L lies in [LMIN, LMAX]. LMIN = floor(floor(CLK_HZ/FAST_BAUD)*63/8) and LMAX = floor(floor(CLK_HZ/SLOW_BAUD)*81/8), which gives 409 and 1053 at the defaults. A pulse outside the window produces no output on txdOut, and the next pulse is measured normally.
- R5: If rxdIn goes low again before one bit period of high has passed after an accepted pulse, no acknowledge is sent. That new low pulse is measured as a fresh attempt.
- R6: After the acknowledge, the byte 0x55 must arrive LSB first at the derived rate with a high stop bit. Each bit is sampled near the middle of its period. When it does, baudLocked becomes 1 and syncError becomes 0. baudLocked stays 0 until then.
- R7: Any confirm byte other than 0x55 sets syncError, leaves baudLocked at 0 and returns the block to measurement.
- R8: A stop bit read as low in the confirm byte sets syncError, leaves baudLocked at 0 and returns the block to measurement, even when the data bits form 0x55.
- R9: Once baudLocked is 1 it stays 1. bitDivisor does not change, txdOut stays high and activity on rxdIn has no effect.
- R10: syncError stays 1 from the first failed confirm until the next successful lock, and lock clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxdIn | input | 1 | Serial receive line from the host, idle high |
| txdOut | output | 1 | Serial transmit line to the host, idle high |
| bitDivisor | output | DIV_W (7 at defaults) | Bit period in clock cycles derived from the measurement |
| baudLocked | output | 1 | High once the confirm byte has been received correctly |
| syncError | output | 1 | High after a failed confirm, until the next lock |

## Verification
Wrong internal state in this block shows up on txdOut within about ten bit periods. A measurement that is wrongly accepted or rejected shows as an acknowledge that should not exist, or one that never comes. A counting or rounding slip changes the acknowledge low time in steps of nine cycles, so the length of each acknowledge is compared against the length the host drove. Errors on the receive side show as the wrong value of baudLocked or syncError one stop bit after the confirm byte ends. After lock, a stray transition or divisor change would appear at once on txdOut or bitDivisor while the host keeps sending.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  // Serial frame: start, 8 data, stop
  localparam int FRAME_BITS = 10;
  localparam int BITCNT_W   = $clog2(FRAME_BITS);

  localparam logic [7:0] ACK_BYTE     = 8'h00;
  localparam logic [7:0] CONFIRM_BYTE = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE_WAIT_HIGH,
    ST_MEASURE_LOW,
    ST_CHECK_HIGH,
    ST_SEND_ACK,
    ST_WAIT_CONFIRM,
    ST_LOCKED,
    ST_ERROR
  } abState_e;

  // Strobes from the controller into the datapath
  typedef struct packed {
    logic lowStart;  // restart low counter at one
    logic lowInc;    // count one more low cycle
    logic latchDiv;  // store rounded divisor, start one-period timer with it
    logic tmrFull;   // reload timer with one bit period
    logic tmrHalf;   // reload timer with half a bit period
    logic txLoad;    // load the acknowledge frame
    logic txShift;   // advance transmit frame by one bit
    logic rxShift;   // shift sampled bit into receive byte
    logic bitClr;    // clear bit counter
    logic bitInc;    // advance bit counter
  } abStrobe_t;

endpackage

// File: rtl/autobaud_dp.sv
module autobaud_dp
  import autobaud_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int DIV_W   = 7,
  parameter int MIN_LOW = 409,
  parameter int MAX_LOW = 1053
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxdIn,
  input  abStrobe_t           strb,
  output logic                rxLvl,
  output logic                rxFall,
  output logic                lowAtMax,
  output logic                lowInWin,
  output logic                tmrZero,
  output logic [BITCNT_W-1:0] bitCnt,
  output logic [7:0]          rxByte,
  output logic                txdOut,
  output logic [DIV_W-1:0]    bitDivisor
);

  localparam int DIV_LO = (MIN_LOW + 4) / 9;
  localparam int DIV_HI = (MAX_LOW + 4) / 9;

  logic rxMeta, rxSync, rxPrev;
  logic [CNT_W-1:0]      lowCnt;
  logic [CNT_W:0]        roundSum;
  logic [DIV_W-1:0]      divCalc, divReg, tmr;
  logic [FRAME_BITS-1:0] txReg;

  // Two-stage synchronizer plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxdIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign rxLvl  = rxSync;
  assign rxFall = rxPrev & ~rxSync;

  // Low-pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lowCnt <= '0;
    else if (strb.lowStart) lowCnt <= CNT_W'(1);
    else if (strb.lowInc)   lowCnt <= lowCnt + 1'b1;
  end

  assign lowAtMax = (lowCnt == CNT_W'(MAX_LOW));
  assign lowInWin = (lowCnt >= CNT_W'(MIN_LOW));

  // Nine bit times per pulse, rounded to nearest
  assign roundSum = {1'b0, lowCnt} + (CNT_W+1)'(4);
  assign divCalc  = DIV_W'(roundSum / (CNT_W+1)'(9));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divReg <= '0;
    else if (strb.latchDiv) divReg <= divCalc;
  end

  assign bitDivisor = divReg;

  // Shared bit-period timer, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (strb.latchDiv) tmr <= divCalc - 1'b1;
    else if (strb.tmrFull)  tmr <= divReg - 1'b1;
    else if (strb.tmrHalf)  tmr <= (divReg >> 1) - 1'b1;
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bitCnt <= '0;
    else if (strb.bitClr) bitCnt <= '0;
    else if (strb.bitInc) bitCnt <= bitCnt + 1'b1;
  end

  // Transmit frame, LSB leaves first, idle ones fill from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReg <= '1;
    else if (strb.txLoad)  txReg <= {1'b1, ACK_BYTE, 1'b0};
    else if (strb.txShift) txReg <= {1'b1, txReg[FRAME_BITS-1:1]};
  end

  assign txdOut = txReg[0];

  // Receive byte, LSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxByte <= '0;
    else if (strb.rxShift) rxByte <= {rxSync, rxByte[7:1]};
  end

  // R4
  lowcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= CNT_W'(MAX_LOW));

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchDiv |=> (divReg >= DIV_W'(DIV_LO) && divReg <= DIV_W'(DIV_HI)));

endmodule

// File: rtl/autobaud_ctrl.sv
module autobaud_ctrl
  import autobaud_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLvl,
  input  logic                rxFall,
  input  logic                lowAtMax,
  input  logic                lowInWin,
  input  logic                tmrZero,
  input  logic [BITCNT_W-1:0] bitCnt,
  input  logic [7:0]          rxByte,
  output abStrobe_t           strb,
  output logic                baudLocked,
  output logic                syncError
);

  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_BITS - 1);

  abState_e state, nxt;
  logic armed, rxActive, rxGo;

  always_comb begin
    strb = '0;
    nxt  = state;
    rxGo = 1'b0;
    unique case (state)
      ST_IDLE_WAIT_HIGH: begin
        if (armed && !rxLvl) begin
          strb.lowStart = 1'b1;
          nxt           = ST_MEASURE_LOW;
        end
      end
      ST_MEASURE_LOW: begin
        if (!rxLvl) begin
          if (lowAtMax) nxt = ST_IDLE_WAIT_HIGH;
          else          strb.lowInc = 1'b1;
        end else if (lowInWin) begin
          strb.latchDiv = 1'b1;
          nxt           = ST_CHECK_HIGH;
        end else begin
          nxt = ST_IDLE_WAIT_HIGH;
        end
      end
      ST_CHECK_HIGH: begin
        if (!rxLvl) begin
          strb.lowStart = 1'b1;
          nxt           = ST_MEASURE_LOW;
        end else if (tmrZero) begin
          strb.txLoad  = 1'b1;
          strb.bitClr  = 1'b1;
          strb.tmrFull = 1'b1;
          nxt          = ST_SEND_ACK;
        end
      end
      ST_SEND_ACK: begin
        if (tmrZero) begin
          if (bitCnt == LAST_BIT) begin
            nxt = ST_WAIT_CONFIRM;
          end else begin
            strb.txShift = 1'b1;
            strb.bitInc  = 1'b1;
            strb.tmrFull = 1'b1;
          end
        end
      end
      ST_WAIT_CONFIRM: begin
        if (!rxActive) begin
          if (rxFall) begin
            rxGo         = 1'b1;
            strb.tmrHalf = 1'b1;
            strb.bitClr  = 1'b1;
          end
        end else if (tmrZero) begin
          if (bitCnt == '0) begin
            if (rxLvl) begin
              nxt = ST_ERROR;
            end else begin
              strb.bitInc  = 1'b1;
              strb.tmrFull = 1'b1;
            end
          end else if (bitCnt == LAST_BIT) begin
            if (rxLvl && rxByte == CONFIRM_BYTE) nxt = ST_LOCKED;
            else                                 nxt = ST_ERROR;
          end else begin
            strb.rxShift = 1'b1;
            strb.bitInc  = 1'b1;
            strb.tmrFull = 1'b1;
          end
        end
      end
      ST_LOCKED: nxt = ST_LOCKED;
      ST_ERROR:  nxt = ST_IDLE_WAIT_HIGH;
      default:   nxt = ST_IDLE_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE_WAIT_HIGH;
      armed     <= 1'b0;
      rxActive  <= 1'b0;
      syncError <= 1'b0;
    end else begin
      state    <= nxt;
      armed    <= (state == ST_IDLE_WAIT_HIGH) && (armed || rxLvl);
      rxActive <= (nxt == ST_WAIT_CONFIRM) && (rxActive || rxGo);
      if (nxt == ST_ERROR)       syncError <= 1'b1;
      else if (nxt == ST_LOCKED) syncError <= 1'b0;
    end
  end

  assign baudLocked = (state == ST_LOCKED);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudLocked |=> baudLocked);

  // R6
  lock_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(baudLocked) |-> (rxByte == CONFIRM_BYTE));

  // R10
  lock_clears_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(baudLocked) |-> !syncError);

endmodule

// File: rtl/autobaud_boot.sv
module autobaud_boot
  import autobaud_pkg::*;
#(
  parameter int  CLK_HZ    = 1_000_000,
  parameter int  SLOW_BAUD = 9600,
  parameter int  FAST_BAUD = 19200,
  localparam int NOM_FAST  = CLK_HZ / FAST_BAUD,
  localparam int NOM_SLOW  = CLK_HZ / SLOW_BAUD,
  localparam int MIN_LOW   = (NOM_FAST * 63) / 8,
  localparam int MAX_LOW   = (NOM_SLOW * 81) / 8,
  localparam int CNT_W     = $clog2(MAX_LOW + 2),
  localparam int DIV_W     = $clog2((MAX_LOW + 4) / 9 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxdIn,
  output logic             txdOut,
  output logic [DIV_W-1:0] bitDivisor,
  output logic             baudLocked,
  output logic             syncError
);

  abStrobe_t             strb;
  logic                  rxLvl, rxFall, lowAtMax, lowInWin, tmrZero;
  logic [BITCNT_W-1:0]   bitCnt;
  logic [7:0]            rxByte;

  autobaud_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxLvl      (rxLvl),
    .rxFall     (rxFall),
    .lowAtMax   (lowAtMax),
    .lowInWin   (lowInWin),
    .tmrZero    (tmrZero),
    .bitCnt     (bitCnt),
    .rxByte     (rxByte),
    .strb       (strb),
    .baudLocked (baudLocked),
    .syncError  (syncError)
  );

  autobaud_dp #(
    .CNT_W   (CNT_W),
    .DIV_W   (DIV_W),
    .MIN_LOW (MIN_LOW),
    .MAX_LOW (MAX_LOW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxdIn      (rxdIn),
    .strb       (strb),
    .rxLvl      (rxLvl),
    .rxFall     (rxFall),
    .lowAtMax   (lowAtMax),
    .lowInWin   (lowInWin),
    .tmrZero    (tmrZero),
    .bitCnt     (bitCnt),
    .rxByte     (rxByte),
    .txdOut     (txdOut),
    .bitDivisor (bitDivisor)
  );

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baudLocked && $past(baudLocked)) |-> $stable(bitDivisor));

  // R9
  quiet_when_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudLocked |-> txdOut);

endmodule

// File: tb/autobaud_boot_bench.sv
module autobaud_boot_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int SLOW_BAUD  = 9600;
  localparam int FAST_BAUD  = 19200;
  localparam int LOW_MIN    = ((CLK_HZ / FAST_BAUD) * 63) / 8;  // 409
  localparam int LOW_MAX    = ((CLK_HZ / SLOW_BAUD) * 81) / 8;  // 1053

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [6:0] div;
  logic       locked, err;

  int errors = 0;
  int checks = 0;
  int expLow[$];

  autobaud_boot #(
    .CLK_HZ(CLK_HZ), .SLOW_BAUD(SLOW_BAUD), .FAST_BAUD(FAST_BAUD)
  ) u_autobaud_boot (
    .clk(clk), .rstN(rstN), .rxdIn(rxd), .txdOut(txd),
    .bitDivisor(div), .baudLocked(locked), .syncError(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int roundDiv(input int len);
    return (len + 4) / 9;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Host drives one low pulse of len cycles; scoreboard gets the ack length
  task automatic hostLow(input int len, input bit expectAck);
    if (expectAck) expLow.push_back(9 * roundDiv(len));
    @(negedge clk);
    rxd = 1'b0;
    repeat (len) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic waitAck();
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input int per, input logic stopLvl);
    @(negedge clk);
    rxd = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (per) @(negedge clk);
    end
    rxd = stopLvl;
    repeat (per) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic expectQuiet(input int n, input string tag);
    int lowSeen;
    lowSeen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lowSeen++;
    end
    check(lowSeen == 0, tag, lowSeen, 0);
  endtask

  // Monitor: every ack on txd is compared with the next scoreboard entry
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rstN && txd === 1'b0) begin
        int lowLen;
        int expv;
        lowLen = 1;
        forever begin
          @(negedge clk);
          if (txd === 1'b1) break;
          lowLen++;
        end
        if (expLow.size() == 0) begin
          check(1'b0, "R4 R9 unexpected ack frame", lowLen, 0);
        end else begin
          expv = expLow.pop_front();
          check(lowLen == expv, "R3 ack low length", lowLen, expv);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    idle(3);
    check(txd == 1'b1, "R1 txd in reset", txd, 1);
    check(locked == 1'b0, "R1 locked in reset", locked, 0);
    rstN = 1'b1;
    idle(3);
    check(txd == 1'b1, "R1 txd after reset", txd, 1);
    check(locked == 1'b0, "R1 locked after reset", locked, 0);
    check(err == 1'b0, "R1 error after reset", err, 0);
    check(div == 0, "R1 divisor after reset", div, 0);
    idle(20);

    // R4 rejected pulses
    hostLow(300, 1'b0);
    expectQuiet(1500, "R4 short pulse ignored");
    hostLow(1200, 1'b0);
    expectQuiet(1500, "R4 long pulse ignored");
    hostLow(LOW_MIN - 1, 1'b0);
    expectQuiet(1500, "R4 just below window");
    hostLow(LOW_MAX + 1, 1'b0);
    expectQuiet(1500, "R4 just above window");

    // Nominal slow rate, wrong confirm byte
    hostLow(936, 1'b1);
    waitAck();
    check(div == 104, "R2 divisor at slow rate", div, 104);
    check(locked == 1'b0, "R6 no lock before confirm", locked, 0);
    idle(208);
    sendByte(8'h33, 104, 1'b1);
    idle(20);
    check(err == 1'b1, "R7 wrong byte error", err, 1);
    check(locked == 1'b0, "R7 wrong byte no lock", locked, 0);

    // Upper boundary, framing error
    hostLow(LOW_MAX, 1'b1);
    waitAck();
    check(div == 117, "R2 divisor at upper bound", div, 117);
    check(err == 1'b1, "R10 error held during retry", err, 1);
    idle(234);
    sendByte(8'h55, 117, 1'b0);
    idle(20);
    check(err == 1'b1, "R8 low stop error", err, 1);
    check(locked == 1'b0, "R8 low stop no lock", locked, 0);

    // Lower boundary, near-miss byte
    hostLow(LOW_MIN, 1'b1);
    waitAck();
    check(div == 45, "R2 divisor at lower bound", div, 45);
    idle(90);
    sendByte(8'h54, 45, 1'b1);
    idle(20);
    check(err == 1'b1, "R7 near byte error", err, 1);
    check(locked == 1'b0, "R7 near byte no lock", locked, 0);

    // Rounding up
    hostLow(725, 1'b1);
    waitAck();
    check(div == 81, "R2 rounding up", div, 81);
    idle(162);
    sendByte(8'hD5, 81, 1'b1);
    idle(20);
    check(err == 1'b1, "R7 high bit byte error", err, 1);

    // R5 early restart: first pulse accepted, high too short, second pulse counts
    hostLow(724, 1'b0);
    idle(9);
    hostLow(468, 1'b1);
    waitAck();
    check(div == 52, "R5 second pulse sets divisor", div, 52);
    check(err == 1'b1, "R10 error held before lock", err, 1);
    idle(104);
    sendByte(8'h55, 52, 1'b1);
    idle(20);
    check(locked == 1'b1, "R6 lock on confirm", locked, 1);
    check(err == 1'b0, "R10 error cleared on lock", err, 0);

    // R9 line ignored once locked
    fork
      begin
        hostLow(936, 1'b0);
        idle(60);
        sendByte(8'hAA, 52, 1'b1);
      end
      expectQuiet(2400, "R9 txd idle while locked");
    join
    check(locked == 1'b1, "R9 lock stays", locked, 1);
    check(div == 52, "R9 divisor frozen", div, 52);

    idle(5);
    check(expLow.size() == 0, "R3 acks all seen", expLow.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule